// File: doc/BRIEF.md
# Power-Fail Supervisor Sequencer

This block watches the supply through three comparator flags that are already digital: supply under the early-warning level, supply under the lowest level at which the processor may run, and supply under the level of the backup cell. It turns these into a staged response. At the first stage it raises a warning interrupt and the processor keeps running. At the second stage it holds the processor in reset and forces the memory bus inactive. At the third stage it also signals switchover to the backup cell.

The reset output is a shared open-drain line. The block pulls it low while it holds a power-fail reset, and it senses the line so that another device pulling it low also resets this block. Its own drive is not mistaken for an external reset. Leaving any reset goes through a fixed power-on delay before the processor is released. A separate, heavily filtered programming input produces one bootstrap-loader request for each press.

Top module: `pwr_supervisor`

## Requirements
- R1: While rst_ni is low, cpu_rst_o and bus_off_o are 1, and warn_irq_o, boot_req_o and bkup_sw_o are 0.
- R2: When the supply level falls to the warning stage while warn_en_i is 1, warn_irq_o pulses high for exactly one cycle with warn_vec_o = 8'h2B. cpu_rst_o stays 0.
- R3: At most one warning pulse is issued per entry into the warning stage. A new pulse needs the supply to return above the warning threshold first (all flags 0). No pulse is issued when warn_en_i is 0 at entry.
- R4: With the minimum-level flag set, cpu_rst_o, bus_off_o and rst_line_oe_o are all 1.
- R5: With the backup flag set, bkup_sw_o is 1 and bkup_act_no is 0, and the reset outputs of R4 are also asserted.
- R6: When the backup flag clears, the block returns to the power-fail reset state (cpu_rst_o and rst_line_oe_o are 1, bkup_sw_o is 0). It never goes straight to run.
- R7: After every power-fail reset, cpu_rst_o is held for exactly POR_CYCLES (default 21504) clocks with the reset line released (rst_line_oe_o = 0) before the processor runs.
- R8: A low level on rst_line_i from outside, while the processor runs, forces reset. The block's own drive on the line does not extend or restart the power-on delay.
- R9: Flag combinations that contradict the threshold order take the most severe stage set: the backup flag alone gives the backup stage, and the minimum flag alone gives the power-fail reset stage.
- R10: prog_ni must be low for 48 clocks to count as pressed and high for 48 clocks to count as released. Each press gives exactly one single-cycle boot_req_o pulse; shorter lows and shorter bounces are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| below_warn_i | input | 1 | Supply below warning threshold |
| below_min_i | input | 1 | Supply below minimum operating level |
| below_bkup_i | input | 1 | Supply below backup-cell level |
| warn_en_i | input | 1 | Warning interrupt enable |
| rst_line_i | input | 1 | Sensed level of the shared open-drain reset line |
| rst_line_oe_o | output | 1 | Pull the shared reset line low |
| prog_ni | input | 1 | Programming request input, active low |
| warn_irq_o | output | 1 | One-cycle warning interrupt request |
| warn_vec_o | output | 8 | Interrupt vector, valid with warn_irq_o |
| cpu_rst_o | output | 1 | Processor reset |
| bus_off_o | output | 1 | Force bus enables and write strobe inactive |
| bkup_sw_o | output | 1 | Switchover to backup cell |
| bkup_act_no | output | 1 | Backup active, active low |
| boot_req_o | output | 1 | One-cycle bootstrap loader request |

## Verification
The supply flags are stepped through ordered descents and ascents: warning only, warning then minimum, all three, and the backup flag cleared alone. These separate a correct stage ladder from one that skips the reset stage on the way up or mixes up the order of the stages. Contradictory flag sets (backup alone, minimum alone) show whether severity is decided by the worst flag or by the flag order. The power-on hold is counted cycle by cycle after a self-driven reset, which exposes both a wrong count and a sequencer that takes its own line drive for an external reset. A short low, a long press, a short bounce and a second clean press on the programming input tell the two filter windows and the one-request-per-press rule apart.

// File: rtl/pwr_sup_pkg.sv
package pwr_sup_pkg;

  typedef enum logic [2:0] {
    ST_POR  = 3'd0,
    ST_RUN  = 3'd1,
    ST_WARN = 3'd2,
    ST_PFR  = 3'd3,
    ST_BKUP = 3'd4
  } state_e;

  typedef enum logic [1:0] {
    LV_OK   = 2'd0,
    LV_WARN = 2'd1,
    LV_MIN  = 2'd2,
    LV_BKUP = 2'd3
  } level_e;

  // worst flag wins, so out-of-order combinations resolve to the most severe stage
  function automatic level_e classify(logic warn, logic min, logic bkup);
    if (bkup)      return LV_BKUP;
    else if (min)  return LV_MIN;
    else if (warn) return LV_WARN;
    else           return LV_OK;
  endfunction

endpackage

// File: rtl/pwr_sync.sv
module pwr_sync #(
  parameter int unsigned      W       = 1,
  parameter int unsigned      STAGES  = 2,
  parameter logic [W-1:0]     RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);

  logic [STAGES-1:0][W-1:0] stg_q;

  if (STAGES == 1) begin : g_one
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) stg_q[0] <= RST_VAL;
      else         stg_q[0] <= d_i;
    end
  end else begin : g_chain
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) stg_q <= {STAGES{RST_VAL}};
      else         stg_q <= {stg_q[STAGES-2:0], d_i};
    end
  end

  assign q_o = stg_q[STAGES-1];

endmodule

// File: rtl/pwr_prog_filter.sv
module pwr_prog_filter #(
  parameter int unsigned FILT_CYCLES = 48
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic prog_s_i,
  output logic boot_req_o
);

  localparam int unsigned CW = $clog2(FILT_CYCLES + 1);
  localparam logic [CW-1:0] LAST = CW'(FILT_CYCLES - 1);

  logic          filt_q;
  logic [CW-1:0] cnt_q;
  logic          req_q;
  logic          mismatch;

  assign mismatch = prog_s_i != filt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      filt_q <= 1'b1;
      cnt_q  <= '0;
      req_q  <= 1'b0;
    end else begin
      req_q <= 1'b0;
      if (!mismatch) begin
        cnt_q <= '0;
      end else if (cnt_q == LAST) begin
        cnt_q  <= '0;
        filt_q <= prog_s_i;
        req_q  <= !prog_s_i;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  assign boot_req_o = req_q;

endmodule

// File: rtl/pwr_seq.sv
module pwr_seq
  import pwr_sup_pkg::*;
#(
  parameter int unsigned POR_CYCLES = 21504
) (
  input  logic   clk_i,
  input  logic   rst_ni,
  input  level_e lvl_i,
  input  logic   ext_low_i,
  input  logic   warn_en_i,
  output state_e state_o,
  output logic   irq_o
);

  localparam int unsigned CW = $clog2(POR_CYCLES + 1);
  localparam logic [CW-1:0] LAST = CW'(POR_CYCLES - 1);

  state_e        st_q, st_d;
  logic [CW-1:0] cnt_q;
  logic          armed_q;
  logic          irq_q;
  logic          enter_warn;

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_POR: begin
        if (lvl_i == LV_BKUP)                 st_d = ST_BKUP;
        else if (lvl_i == LV_MIN)             st_d = ST_PFR;
        else if (!ext_low_i && cnt_q == LAST) st_d = ST_RUN;
      end
      ST_RUN, ST_WARN: begin
        if (lvl_i == LV_BKUP)                    st_d = ST_BKUP;
        else if (lvl_i == LV_MIN || ext_low_i)   st_d = ST_PFR;
        else if (lvl_i == LV_WARN)               st_d = ST_WARN;
        else                                     st_d = ST_RUN;
      end
      ST_PFR: begin
        if (lvl_i == LV_BKUP)     st_d = ST_BKUP;
        else if (lvl_i != LV_MIN) st_d = ST_POR;
      end
      ST_BKUP: begin
        if (lvl_i != LV_BKUP) st_d = ST_PFR;
      end
      default: st_d = ST_PFR;
    endcase
  end

  assign enter_warn = (st_d == ST_WARN) && (st_q != ST_WARN);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= ST_POR;
      cnt_q   <= '0;
      armed_q <= 1'b0;
      irq_q   <= 1'b0;
    end else begin
      st_q <= st_d;
      // external pull inside the hold window restarts it
      if (st_q == ST_POR && !ext_low_i) cnt_q <= cnt_q + 1'b1;
      else                              cnt_q <= '0;
      if (lvl_i == LV_OK)   armed_q <= 1'b1;
      else if (enter_warn)  armed_q <= 1'b0;
      irq_q <= enter_warn && armed_q && warn_en_i;
    end
  end

  assign state_o = st_q;
  assign irq_o   = irq_q;

endmodule

// File: rtl/pwr_supervisor.sv
module pwr_supervisor
  import pwr_sup_pkg::*;
#(
  parameter int unsigned POR_CYCLES  = 21504,
  parameter int unsigned FILT_CYCLES = 48,
  parameter int unsigned SYNC_STAGES = 2,
  parameter logic [7:0]  WARN_VEC    = 8'h2B
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       below_warn_i,
  input  logic       below_min_i,
  input  logic       below_bkup_i,
  input  logic       warn_en_i,
  input  logic       rst_line_i,
  output logic       rst_line_oe_o,
  input  logic       prog_ni,
  output logic       warn_irq_o,
  output logic [7:0] warn_vec_o,
  output logic       cpu_rst_o,
  output logic       bus_off_o,
  output logic       bkup_sw_o,
  output logic       bkup_act_no,
  output logic       boot_req_o
);

  // own drive echoes through the line synchroniser for this many cycles
  localparam int unsigned HIST = SYNC_STAGES + 1;

  logic [2:0]      flags_s;
  logic            line_s;
  logic            prog_s;
  logic [HIST-1:0] oe_hist_q;
  logic            ext_low;
  logic            irq;
  level_e          lvl;
  state_e          state;

  pwr_sync #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b111)) i_sync_flags (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({below_bkup_i, below_min_i, below_warn_i}),
    .q_o   (flags_s)
  );

  pwr_sync #(.W(2), .STAGES(SYNC_STAGES), .RST_VAL(2'b11)) i_sync_pins (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({rst_line_i, prog_ni}),
    .q_o   ({line_s, prog_s})
  );

  assign lvl = classify(flags_s[0], flags_s[1], flags_s[2]);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) oe_hist_q <= '0;
    else         oe_hist_q <= {oe_hist_q[HIST-2:0], rst_line_oe_o};
  end

  assign ext_low = !line_s && !rst_line_oe_o && !(|oe_hist_q);

  pwr_seq #(.POR_CYCLES(POR_CYCLES)) i_seq (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .lvl_i    (lvl),
    .ext_low_i(ext_low),
    .warn_en_i(warn_en_i),
    .state_o  (state),
    .irq_o    (irq)
  );

  pwr_prog_filter #(.FILT_CYCLES(FILT_CYCLES)) i_prog (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .prog_s_i  (prog_s),
    .boot_req_o(boot_req_o)
  );

  assign rst_line_oe_o = (state == ST_PFR) || (state == ST_BKUP);
  assign cpu_rst_o     = (state == ST_PFR) || (state == ST_BKUP) || (state == ST_POR);
  assign bus_off_o     = cpu_rst_o;
  assign bkup_sw_o     = state == ST_BKUP;
  assign bkup_act_no   = !bkup_sw_o;
  assign warn_irq_o    = irq;
  assign warn_vec_o    = irq ? WARN_VEC : 8'h00;

endmodule

// File: rtl/pwr_supervisor_chk.sv
module pwr_supervisor_chk #(
  parameter logic [7:0] WARN_VEC = 8'h2B
) (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       warn_en_i,
  input logic       rst_line_oe_o,
  input logic       warn_irq_o,
  input logic [7:0] warn_vec_o,
  input logic       cpu_rst_o,
  input logic       bus_off_o,
  input logic       bkup_sw_o,
  input logic       bkup_act_no,
  input logic       boot_req_o
);

  a_r2_irq_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    warn_irq_o |=> !warn_irq_o);

  a_r2_irq_running: assert property (@(posedge clk_i) disable iff (!rst_ni)
    warn_irq_o |-> !cpu_rst_o && warn_vec_o == WARN_VEC);

  a_r3_irq_needs_en: assert property (@(posedge clk_i) disable iff (!rst_ni)
    warn_irq_o |-> $past(warn_en_i));

  a_r4_line_in_reset: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_line_oe_o |-> cpu_rst_o && bus_off_o);

  a_r5_backup_in_reset: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bkup_sw_o |-> cpu_rst_o && rst_line_oe_o && !bkup_act_no);

  a_r6_backup_exit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(bkup_sw_o) |-> cpu_rst_o && rst_line_oe_o);

  a_r7_run_after_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(cpu_rst_o) |-> $past(!rst_line_oe_o));

  a_r10_boot_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    boot_req_o |=> !boot_req_o);

endmodule

bind pwr_supervisor pwr_supervisor_chk #(.WARN_VEC(WARN_VEC)) i_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .warn_en_i    (warn_en_i),
  .rst_line_oe_o(rst_line_oe_o),
  .warn_irq_o   (warn_irq_o),
  .warn_vec_o   (warn_vec_o),
  .cpu_rst_o    (cpu_rst_o),
  .bus_off_o    (bus_off_o),
  .bkup_sw_o    (bkup_sw_o),
  .bkup_act_no  (bkup_act_no),
  .boot_req_o   (boot_req_o)
);

// File: tb/test_pwr_supervisor.sv
`timescale 1ns/1ps
module test_pwr_supervisor;

  localparam int POR_N = 21504;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       b_warn = 1'b1, b_min = 1'b1, b_bkup = 1'b1;
  logic       warn_en = 1'b1;
  logic       ext_pull = 1'b0;
  logic       prog_n = 1'b1;
  logic       line;
  logic       line_oe, irq, cpu_rst, bus_off, bkup_sw, bkup_act_n, boot_req;
  logic [7:0] vec;

  int checks = 0, errors = 0;
  int irq_cnt = 0, boot_cnt = 0, oe_cnt = 0, bad_vec = 0;

  always #5 clk = ~clk;

  assign line = !(line_oe || ext_pull);

  pwr_supervisor i_pwr_supervisor (
    .clk_i(clk), .rst_ni(rst_n),
    .below_warn_i(b_warn), .below_min_i(b_min), .below_bkup_i(b_bkup),
    .warn_en_i(warn_en), .rst_line_i(line), .rst_line_oe_o(line_oe),
    .prog_ni(prog_n), .warn_irq_o(irq), .warn_vec_o(vec),
    .cpu_rst_o(cpu_rst), .bus_off_o(bus_off), .bkup_sw_o(bkup_sw),
    .bkup_act_no(bkup_act_n), .boot_req_o(boot_req)
  );

  always @(negedge clk) begin
    if (irq) begin
      irq_cnt++;
      if (vec != 8'h2B) bad_vec++;
    end
    if (boot_req) boot_cnt++;
    if (line_oe) oe_cnt++;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic set_flags(input logic w, input logic m, input logic b);
    b_warn = w; b_min = m; b_bkup = b;
  endtask

  // counts cycles held in reset with the line released, until run
  task automatic hold_len(output int n);
    n = 0;
    for (int i = 0; i < 40000; i++) begin
      @(negedge clk);
      if (!cpu_rst) break;
      if (!line_oe) n++;
    end
  endtask

  task automatic wait_run();
    for (int i = 0; i < 40000; i++) begin
      @(negedge clk);
      if (!cpu_rst) break;
    end
  endtask

  task automatic t_reset();
    cyc(3);
    chk(cpu_rst && bus_off, "R1 reset outputs", {30'd0, cpu_rst, bus_off}, 3);
    chk(!irq && !boot_req && !bkup_sw, "R1 quiet outputs", {29'd0, irq, boot_req, bkup_sw}, 0);
  endtask

  task automatic t_power_up();
    int n;
    rst_n = 1'b1;
    cyc(6);
    chk(bkup_sw && !bkup_act_n && cpu_rst && line_oe, "R5 backup at power-up",
        {28'd0, bkup_sw, bkup_act_n, cpu_rst, line_oe}, 4'b1011);
    set_flags(1, 1, 0);
    cyc(6);
    chk(!bkup_sw && bkup_act_n && cpu_rst && line_oe, "R6 backup exit to reset",
        {28'd0, bkup_sw, bkup_act_n, cpu_rst, line_oe}, 4'b0111);
    set_flags(0, 0, 0);
    hold_len(n);
    chk(n == POR_N, "R7 hold length after power-up", n, POR_N);
    chk(!cpu_rst && !bus_off, "R7 running after hold", {30'd0, cpu_rst, bus_off}, 0);
  endtask

  task automatic t_warn();
    int c0;
    c0 = irq_cnt;
    warn_en = 1'b1;
    b_warn = 1'b1;
    cyc(6);
    chk(irq_cnt == c0 + 1, "R2 warning pulse", irq_cnt - c0, 1);
    chk(!cpu_rst, "R2 keeps running", cpu_rst, 0);
    cyc(30);
    chk(irq_cnt == c0 + 1, "R3 single pulse while held", irq_cnt - c0, 1);
    b_warn = 1'b0; cyc(6);
    b_warn = 1'b1; cyc(6);
    chk(irq_cnt == c0 + 2, "R3 rearm after recovery", irq_cnt - c0, 2);
    b_warn = 1'b0; cyc(6);
    warn_en = 1'b0;
    b_warn = 1'b1; cyc(6);
    chk(irq_cnt == c0 + 2, "R3 disabled warning", irq_cnt - c0, 2);
    b_warn = 1'b0; cyc(6);
    warn_en = 1'b1;
    chk(bad_vec == 0, "R2 vector 2Bh", bad_vec, 0);
  endtask

  task automatic t_min();
    int c0, n;
    b_warn = 1'b1; cyc(6);
    c0 = irq_cnt;
    b_min = 1'b1; cyc(6);
    chk(cpu_rst && bus_off && line_oe, "R4 minimum level reset",
        {29'd0, cpu_rst, bus_off, line_oe}, 7);
    b_min = 1'b0;
    hold_len(n);
    chk(n == POR_N, "R8 own drive does not extend hold", n, POR_N);
    cyc(6);
    chk(!cpu_rst && irq_cnt == c0, "R3 no pulse without recovery", irq_cnt - c0, 0);
    b_warn = 1'b0; cyc(6);
  endtask

  task automatic t_backup_return();
    int n;
    set_flags(1, 1, 1); cyc(6);
    chk(bkup_sw && !bkup_act_n, "R5 backup stage", {30'd0, bkup_sw, bkup_act_n}, 2);
    b_bkup = 1'b0; cyc(6);
    chk(cpu_rst && line_oe && !bkup_sw, "R6 return lands in reset",
        {29'd0, cpu_rst, line_oe, bkup_sw}, 6);
    set_flags(0, 0, 0);
    hold_len(n);
    chk(n == POR_N, "R6 full hold after backup", n, POR_N);
  endtask

  task automatic t_inconsistent();
    set_flags(0, 0, 1); cyc(6);
    chk(bkup_sw && cpu_rst, "R9 backup flag alone", {30'd0, bkup_sw, cpu_rst}, 3);
    set_flags(0, 0, 0); wait_run();
    set_flags(0, 1, 0); cyc(6);
    chk(cpu_rst && line_oe && !bkup_sw, "R9 minimum flag alone",
        {29'd0, cpu_rst, line_oe, bkup_sw}, 6);
    set_flags(0, 0, 0); wait_run();
    chk(!cpu_rst, "R9 recovered", cpu_rst, 0);
  endtask

  task automatic t_ext_reset();
    int o0;
    o0 = oe_cnt;
    ext_pull = 1'b1; cyc(6);
    chk(cpu_rst && bus_off, "R8 external reset", {30'd0, cpu_rst, bus_off}, 3);
    chk(oe_cnt > o0, "R8 line joined", oe_cnt - o0, 1);
    cyc(10);
    ext_pull = 1'b0;
    wait_run();
    chk(!cpu_rst, "R8 runs after release", cpu_rst, 0);
  endtask

  task automatic t_prog();
    int b0;
    b0 = boot_cnt;
    prog_n = 1'b0; cyc(40); prog_n = 1'b1; cyc(100);
    chk(boot_cnt == b0, "R10 short low ignored", boot_cnt - b0, 0);
    prog_n = 1'b0; cyc(100);
    chk(boot_cnt == b0 + 1, "R10 press gives request", boot_cnt - b0, 1);
    prog_n = 1'b1; cyc(20); prog_n = 1'b0; cyc(100);
    chk(boot_cnt == b0 + 1, "R10 bounce ignored", boot_cnt - b0, 1);
    prog_n = 1'b1; cyc(100); prog_n = 1'b0; cyc(100);
    chk(boot_cnt == b0 + 2, "R10 second press", boot_cnt - b0, 2);
    prog_n = 1'b1; cyc(100);
  endtask

  initial begin
    t_reset();
    t_power_up();
    t_warn();
    t_min();
    t_backup_return();
    t_inconsistent();
    t_ext_reset();
    t_prog();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog actual 1 expected 0");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule